// File: doc/BRIEF.md
# Operand Readiness Interlock

This block decides, each cycle, whether the micro-operation waiting at the issue stage of a short in-order pipeline may advance. The pipeline runs issue/address generation, then execute, then a load-completion stage. Every accepted micro-operation that writes a register is recorded in a small tracker, together with the stage at which its result can be forwarded: execute for arithmetic, move, multiply, divide and base-update results, and load completion for loaded data. The tracker shifts one place per clock and drops an entry once it has passed load completion.

The waiting micro-operation presents up to two source registers. Each source is tagged with the stage that consumes it: issue for address operands, or execute for data operands. For every tracked producer the block works out how many cycles the consumer would have to wait before the value can be forwarded. The consumer is held back while any of these waits is non-zero. For each source the block also reports where the value will come from: the execute result path, the load-completion path, or the register file.

The issue port is a valid/ready handshake. `iss_ready` depends only on the presented descriptor and on the tracked producers, never on `iss_valid`. While `iss_valid` is high and `iss_ready` is low, the upstream stage must hold the descriptor stable. In each such cycle an empty slot (a bubble) enters the tracker. A micro-operation is recorded only in a cycle where both `iss_valid` and `iss_ready` are high. `flush` empties the tracker and discards any micro-operation accepted in the same cycle.

Top module: `operand_interlock`

## Requirements
- R1: Out of reset the tracker is empty: `iss_ready` is 1, and every `fwd_sel` reads 0 (register file).
- R2: A producer whose result is ready at execute (`iss_dst_late`=0) causes no stall to an execute-need consumer (`iss_src_early`=0) issued directly behind it, and that source's `fwd_sel` is 1 (execute path).
- R3: A producer ready at load completion (`iss_dst_late`=1), followed directly by an execute-need consumer, holds the consumer for exactly 1 cycle. When the consumer is accepted, its `fwd_sel` is 2 (load-completion path).
- R4: An execute-ready producer directly ahead of an address consumer (`iss_src_early`=1) holds it for exactly 1 cycle, and the consumer is accepted with `fwd_sel` 1.
- R5: A load-completion producer directly ahead of an address consumer holds it for exactly 2 cycles. The consumer is accepted with `fwd_sel` 0, because the producer has retired.
- R6: The wait is (ready stage − need stage − distance + 1), floored at zero. The stages are numbered issue=1, execute=2, load completion=3, and the distance is the number of cycles since the producer was accepted. So with one idle cycle after a load, an execute-need consumer waits 0 cycles and an address consumer waits 1 cycle.
- R7: With two sources, the stall lasts as long as the larger of the two waits, and each source gets its own `fwd_sel`.
- R8: When more than one tracked producer writes the same register, `fwd_sel` follows the most recently accepted one.
- R9: A producer with `iss_dst_vld`=0, a source with `iss_src_vld`=0, or an entry removed by `flush` never causes a stall or a forwarding select.
- R10: A micro-operation enters the tracker only on a cycle with `iss_valid` and `iss_ready` both high. A stalled cycle inserts a bubble, so a stalled consumer is recorded once and can itself forward to the next consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the tracker; an acceptance in the same cycle is dropped |
| iss_valid | input | 1 | A micro-operation is present at issue |
| iss_ready | output | 1 | High when no source needs to wait |
| iss_dst_vld | input | 1 | The micro-operation writes a register |
| iss_dst | input | REG_W (5) | Destination register |
| iss_dst_late | input | 1 | 1: result ready at load completion; 0: ready at execute |
| iss_src_vld | input | NUM_SRC (2) | Per-source valid |
| iss_src_reg | input | NUM_SRC×REG_W | Source register numbers |
| iss_src_early | input | NUM_SRC (2) | 1: source needed at issue (address); 0: needed at execute |
| fwd_sel | output | NUM_SRC×2 | Per-source select: 0 register file, 1 execute path, 2 load-completion path |

## Verification
The assertions rely on two properties of the inputs. The descriptor must be held steady while `iss_valid` is high and `iss_ready` is low. `flush` must only be raised in cycles where nothing is being presented. Under those conditions a hold can last at most two cycles, and a hold can only come from an occupied tracker slot. The bench's driver task raises `iss_valid` at a falling edge and keeps every descriptor field unchanged until it sees `iss_ready`. It raises `flush` only during an idle cycle with `iss_valid` low. Idle gaps are inserted explicitly, so that producer distances of one and two cycles are both covered.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  localparam int STG_ISSUE = 1;
  localparam int STG_EXEC  = 2;
  localparam int STG_LDONE = 3;

  typedef enum logic [1:0] {
    FWD_REGFILE = 2'd0,
    FWD_EXEC    = 2'd1,
    FWD_LDONE   = 2'd2
  } fwd_sel_e;

  // cycles the consumer still has to wait for a producer sitting in slot k
  function automatic int wait_cycles(input logic late, input logic early, input int k);
    int rdy;
    int need;
    int w;
    rdy  = late ? STG_LDONE : STG_EXEC;
    need = early ? STG_ISSUE : STG_EXEC;
    w    = rdy - need - k;
    return (w > 0) ? w : 0;
  endfunction

endpackage

// File: rtl/ilk_slot_pipe.sv
module ilk_slot_pipe #(
  parameter int REG_W    = 5,
  parameter int NUM_SLOT = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic [REG_W-1:0]               push_dst,
  input  logic                           push_late,
  output logic [NUM_SLOT-1:0]            slot_vld,
  output logic [NUM_SLOT-1:0][REG_W-1:0] slot_dst,
  output logic [NUM_SLOT-1:0]            slot_late
);

  genvar k;
  generate
    for (k = 0; k < NUM_SLOT; k++) begin : g_slot
      logic             nxt_vld;
      logic [REG_W-1:0] nxt_dst;
      logic             nxt_late;

      if (k == 0) begin : g_head
        assign nxt_vld  = push;
        assign nxt_dst  = push_dst;
        assign nxt_late = push_late;
      end else begin : g_body
        assign nxt_vld  = slot_vld[k-1];
        assign nxt_dst  = slot_dst[k-1];
        assign nxt_late = slot_late[k-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_vld[k]  <= 1'b0;
          slot_dst[k]  <= '0;
          slot_late[k] <= 1'b0;
        end else if (flush) begin
          slot_vld[k]  <= 1'b0;
          slot_dst[k]  <= '0;
          slot_late[k] <= 1'b0;
        end else begin
          slot_vld[k]  <= nxt_vld;
          slot_dst[k]  <= nxt_vld ? nxt_dst : '0;
          slot_late[k] <= nxt_vld & nxt_late;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ilk_src_check.sv
module ilk_src_check
  import ilk_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int NUM_SLOT = 2
) (
  input  logic                           src_vld,
  input  logic [REG_W-1:0]               src_reg,
  input  logic                           src_early,
  input  logic [NUM_SLOT-1:0]            slot_vld,
  input  logic [NUM_SLOT-1:0][REG_W-1:0] slot_dst,
  input  logic [NUM_SLOT-1:0]            slot_late,
  output logic                           hazard,
  output fwd_sel_e                       sel
);

  logic [NUM_SLOT-1:0] hit;
  logic [NUM_SLOT-1:0] blocks;

  genvar k;
  generate
    for (k = 0; k < NUM_SLOT; k++) begin : g_cmp
      assign hit[k]    = src_vld && slot_vld[k] && (slot_dst[k] == src_reg);
      assign blocks[k] = hit[k] && (wait_cycles(slot_late[k], src_early, k) != 0);
    end
  endgenerate

  assign hazard = |blocks;

  // oldest first, so the youngest matching slot (index 0) wins
  always_comb begin
    sel = FWD_REGFILE;
    for (int j = NUM_SLOT - 1; j >= 0; j--) begin
      if (hit[j]) sel = slot_late[j] ? FWD_LDONE : FWD_EXEC;
    end
  end

endmodule

// File: rtl/operand_interlock.sv
module operand_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          iss_valid,
  output logic                          iss_ready,
  input  logic                          iss_dst_vld,
  input  logic [REG_W-1:0]              iss_dst,
  input  logic                          iss_dst_late,
  input  logic [NUM_SRC-1:0]            iss_src_vld,
  input  logic [NUM_SRC-1:0][REG_W-1:0] iss_src_reg,
  input  logic [NUM_SRC-1:0]            iss_src_early,
  output logic [NUM_SRC-1:0][1:0]       fwd_sel
);

  localparam int NUM_SLOT = STG_LDONE - STG_ISSUE;

  logic [NUM_SLOT-1:0]            slot_vld;
  logic [NUM_SLOT-1:0][REG_W-1:0] slot_dst;
  logic [NUM_SLOT-1:0]            slot_late;
  logic [NUM_SRC-1:0]             src_haz;
  logic                           accept;

  assign iss_ready = ~(|src_haz);
  assign accept    = iss_valid & iss_ready;

  ilk_slot_pipe #(.REG_W(REG_W), .NUM_SLOT(NUM_SLOT)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (accept & iss_dst_vld),
    .push_dst  (iss_dst),
    .push_late (iss_dst_late),
    .slot_vld  (slot_vld),
    .slot_dst  (slot_dst),
    .slot_late (slot_late)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_src
      fwd_sel_e s;
      ilk_src_check #(.REG_W(REG_W), .NUM_SLOT(NUM_SLOT)) u_chk (
        .src_vld   (iss_src_vld[i]),
        .src_reg   (iss_src_reg[i]),
        .src_early (iss_src_early[i]),
        .slot_vld  (slot_vld),
        .slot_dst  (slot_dst),
        .slot_late (slot_late),
        .hazard    (src_haz[i]),
        .sel       (s)
      );
      assign fwd_sel[i] = s;
    end
  endgenerate

endmodule

// File: rtl/operand_interlock_chk.sv
module operand_interlock_chk #(
  parameter int NUM_SLOT = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                iss_valid,
  input logic                iss_ready,
  input logic                iss_dst_vld,
  input logic [NUM_SLOT-1:0] slot_vld
);

  // R9: a hold always traces back to an occupied tracker slot
  assert_stall_has_producer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> (slot_vld != '0));

  // R9: after a flush nothing is left to wait on
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> iss_ready);

  // R10: a held cycle puts a bubble into the tracker
  assert_bubble_on_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_ready && !flush) |=> !slot_vld[0]);

  // R10: an accepted register writer is recorded
  assert_accept_recorded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_dst_vld && !flush) |=> slot_vld[0]);

  // R5: no hold can exceed two cycles
  assert_hold_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_ready && $past(!iss_ready)) |=> iss_ready);

endmodule

bind operand_interlock operand_interlock_chk #(.NUM_SLOT(NUM_SLOT)) u_ilk_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .iss_dst_vld (iss_dst_vld),
  .slot_vld    (slot_vld)
);

// File: tb/operand_interlock_tb.sv
module operand_interlock_tb;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            flush = 1'b0;
  logic            iss_valid = 1'b0;
  logic            iss_ready;
  logic            iss_dst_vld = 1'b0;
  logic [4:0]      iss_dst = '0;
  logic            iss_dst_late = 1'b0;
  logic [1:0]      iss_src_vld = '0;
  logic [1:0][4:0] iss_src_reg = '0;
  logic [1:0]      iss_src_early = '0;
  logic [1:0][1:0] fwd_sel;

  always #2.5 clk = ~clk;

  operand_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_dst_vld(iss_dst_vld), .iss_dst(iss_dst),
    .iss_dst_late(iss_dst_late), .iss_src_vld(iss_src_vld),
    .iss_src_reg(iss_src_reg), .iss_src_early(iss_src_early), .fwd_sel(fwd_sel)
  );

  typedef struct {
    int    stall;
    int    sel0;
    int    sel1;
    string tag;
  } exp_t;

  exp_t       expq[$];
  int         h_acc[$];
  logic [4:0] h_dst[$];
  bit         h_late[$];
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int pen_of(bit v, logic [4:0] r, bit early, int t0);
    int s = 0;
    if (!v) return 0;
    foreach (h_acc[j]) begin
      if (h_dst[j] == r) begin
        int p = (h_late[j] ? 3 : 2) - (early ? 1 : 2) - (t0 - h_acc[j]) + 1;
        if (p > s) s = p;
      end
    end
    return s;
  endfunction

  function automatic int sel_of(bit v, logic [4:0] r, int t1);
    int best = -1000;
    int sel = 0;
    if (!v) return 0;
    foreach (h_acc[j]) begin
      if (h_dst[j] == r && (t1 - h_acc[j]) <= 2 && h_acc[j] > best) begin
        best = h_acc[j];
        sel = h_late[j] ? 2 : 1;
      end
    end
    return sel;
  endfunction

  // driver: computes the expectation, then presents and holds until accepted
  task automatic issue(input string tag, input bit dv, input logic [4:0] d, input bit late,
                       input bit v0, input logic [4:0] r0, input bit e0,
                       input bit v1, input logic [4:0] r1, input bit e1);
    exp_t e;
    int   t0;
    bit   acc;
    t0 = cyc;
    e.stall = pen_of(v0, r0, e0, t0);
    if (pen_of(v1, r1, e1, t0) > e.stall) e.stall = pen_of(v1, r1, e1, t0);
    e.sel0 = sel_of(v0, r0, t0 + e.stall);
    e.sel1 = sel_of(v1, r1, t0 + e.stall);
    e.tag = tag;
    expq.push_back(e);
    iss_valid = 1'b1; iss_dst_vld = dv; iss_dst = d; iss_dst_late = late;
    iss_src_vld = {v1, v0}; iss_src_reg = {r1, r0}; iss_src_early = {e1, e0};
    acc = 0;
    while (!acc) begin
      #1;
      acc = iss_ready;
      if (acc && dv) begin
        h_acc.push_back(cyc); h_dst.push_back(d); h_late.push_back(late);
      end
      @(negedge clk);
    end
    iss_valid = 1'b0; iss_src_vld = '0; iss_dst_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    iss_valid = 1'b0; iss_src_vld = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_flush();
    iss_valid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    h_acc.delete(); h_dst.delete(); h_late.delete();
  endtask

  // monitor: counts held cycles and compares at each acceptance
  initial begin
    int held = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && iss_valid && !iss_ready) held++;
      else if (rst_n && iss_valid && iss_ready) begin
        exp_t e;
        if (expq.size() == 0) begin
          check("unexpected acceptance", 1, 0);
        end else begin
          e = expq.pop_front();
          check({e.tag, " hold cycles"}, held, e.stall);
          check({e.tag, " fwd_sel[0]"}, int'(fwd_sel[0]), e.sel0);
          check({e.tag, " fwd_sel[1]"}, int'(fwd_sel[1]), e.sel1);
        end
        held = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 ready after reset", int'(iss_ready), 1);
    check("R1 sel0 after reset", int'(fwd_sel[0]), 0);
    check("R1 sel1 after reset", int'(fwd_sel[1]), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 ready released", int'(iss_ready), 1);
    @(negedge clk);

    issue("R2 alu producer", 1, 5, 0, 0, 0, 0, 0, 0, 0);
    issue("R2 exec consumer", 1, 6, 0, 1, 5, 0, 0, 0, 0);
    idle(3);
    issue("R3 load producer", 1, 7, 1, 0, 0, 0, 0, 0, 0);
    issue("R3 exec consumer", 0, 0, 0, 1, 7, 0, 0, 0, 0);
    idle(3);
    issue("R4 alu producer", 1, 8, 0, 0, 0, 0, 0, 0, 0);
    issue("R4 address consumer", 0, 0, 0, 1, 8, 1, 0, 0, 0);
    idle(3);
    issue("R5 load producer", 1, 9, 1, 0, 0, 0, 0, 0, 0);
    issue("R5 address consumer", 1, 20, 0, 1, 9, 1, 0, 0, 0);
    issue("R10 follower of held op", 0, 0, 0, 0, 0, 0, 1, 20, 0);
    idle(3);
    issue("R6 load gap exec", 1, 10, 1, 0, 0, 0, 0, 0, 0);
    idle(1);
    issue("R6 exec consumer gap", 0, 0, 0, 1, 10, 0, 0, 0, 0);
    idle(3);
    issue("R6 load gap addr", 1, 11, 1, 0, 0, 0, 0, 0, 0);
    idle(1);
    issue("R6 address consumer gap", 0, 0, 0, 1, 11, 1, 0, 0, 0);
    idle(3);
    issue("R7 alu producer", 1, 12, 0, 0, 0, 0, 0, 0, 0);
    issue("R7 load producer", 1, 13, 1, 0, 0, 0, 0, 0, 0);
    issue("R7 dual consumer", 0, 0, 0, 1, 12, 0, 1, 13, 0);
    idle(3);
    issue("R7 dual address", 1, 22, 1, 0, 0, 0, 0, 0, 0);
    issue("R7 dual address consumer", 0, 0, 0, 1, 22, 0, 1, 22, 1);
    idle(3);
    issue("R8 older load", 1, 14, 1, 0, 0, 0, 0, 0, 0);
    issue("R8 younger alu", 1, 14, 0, 0, 0, 0, 0, 0, 0);
    issue("R8 consumer", 0, 0, 0, 1, 14, 0, 0, 0, 0);
    idle(3);
    issue("R9 no-dest load", 0, 15, 1, 0, 0, 0, 0, 0, 0);
    issue("R9 consumer of no-dest", 0, 0, 0, 1, 15, 0, 0, 0, 0);
    idle(3);
    issue("R9 load for invalid src", 1, 16, 1, 0, 0, 0, 0, 0, 0);
    issue("R9 invalid source", 0, 0, 0, 0, 16, 1, 0, 0, 0);
    idle(3);
    issue("R9 load before flush", 1, 17, 1, 0, 0, 0, 0, 0, 0);
    do_flush();
    issue("R9 consumer after flush", 0, 0, 0, 1, 17, 1, 0, 0, 0);
    idle(4);

    check("R10 all expectations consumed", expq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule